// File: doc/BRIEF.md
# Clock-Output Serial Receiver with Flow-Stop

This block is a synchronous serial receiver that acts as the clock master of its link. It generates the serial clock, samples one data line and assembles 8-bit frames, least significant bit first. Completed frames move forward through a chain of storage stages to a read port. The block cannot overrun. When every storage stage holds an unread byte, it parks its own clock high at a byte boundary. It starts the clock again once software has read enough to make room.

A build-time parameter picks the storage chain:
- **single:** one buffer. Every byte is then a handshake.
- **double:** a holding shift stage plus the buffer.
- **fifo:** the shift stage, the buffer and a small FIFO. Each read pops the FIFO head. The buffer then drops into the FIFO and the shift stage into the buffer.

Software controls reception with a receive-enable bit. An auto-disable option makes the hardware clear that bit at the moment storage fills, which ends reception until software enables it again.

Top module: `sclk_rx_flowstop`

## Requirements
- R1: After reset `sclk` is 1, and `data_avail`, `rx_enable` and `store_full` are 0.
- R2: `sclk` idles at 1. A byte is 8 pairs of a low phase and a high phase, each HALF_PERIOD `clk` cycles long. `sdata` is sampled at each rising `sclk` edge, and the first sampled bit lands in `rd_data` bit 0.
- R3: With MODE 0 (single buffer), at most one unread byte is held. The clock stops after every byte and restarts only after that byte is read.
- R4: With MODE 1 (double buffer), the clock stops only when two unread bytes are held, one in the shift stage and one in the buffer. One read lets exactly one more byte be received.
- R5: With MODE 2 (FIFO), the clock stops only when FIFO_DEPTH+2 unread bytes are held. One read pops the FIFO head, the buffer and shift stage move forward, and exactly one more byte is received.
- R6: Bytes are delivered in the order received, with none lost or overwritten, however slowly they are read. `rd_data` and `data_avail` hold steady until a read.
- R7: A byte starts only while `rx_enable` is 1 and the first storage stage is free. The clock stops only at a byte boundary with `sclk` at 1. `sclk` is 1 whenever `store_full` is 1.
- R8: With `auto_dis` at 1, the cycle after storage fills with the clock idle, `rx_enable` drops to 0. Reading the stored bytes then does not restart the clock.
- R9: A read strobe while `data_avail` is 0 has no effect.
- R10: Writing 0 to the enable bit in mid-byte lets that byte finish and be stored readable. No further byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data line |
| en_wr | input | 1 | Write strobe for the receive-enable bit |
| en_val | input | 1 | Value written to the receive-enable bit |
| auto_dis | input | 1 | Clear receive-enable when storage fills |
| rd_stb | input | 1 | Consume the byte on `rd_data` |
| sclk | output | 1 | Generated serial clock, idle high |
| rd_data | output | DATA_W | Oldest unread byte |
| data_avail | output | 1 | `rd_data` holds an unread byte |
| rx_enable | output | 1 | Current receive-enable bit |
| store_full | output | 1 | Every storage stage holds unread data |

## Verification
The bench fills each of the three storage variants until the clock stops. It counts the bytes the serial source actually shifted out, so a design with the wrong stop point shows up as one byte too many or too few. A design that lets storage overflow would show up as a corrupted or missing byte in the ordered readback, and the bench drives that readback with random read gaps.

Four corner cases get their own directed tests:
- A read strobe on empty storage. A design that honoured it would skip or corrupt the first byte.
- Disabling in mid-byte. A design that cut the clock at once would leave the source mid-frame and store nothing.
- Auto-disable. A design that restarted after the reads would shift out extra bytes.
- Phase widths of the clock. These are checked to catch an off-by-one half period.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  localparam int MODE_SINGLE = 0;
  localparam int MODE_DOUBLE = 1;
  localparam int MODE_FIFO   = 2;

  typedef enum logic [1:0] {
    SM_IDLE = 2'd0,
    SM_LOW  = 2'd1,
    SM_HIGH = 2'd2
  } sclk_state_t;

  function automatic int stage_capacity(input int mode, input int depth);
    case (mode)
      MODE_SINGLE: return 1;
      MODE_DOUBLE: return 2;
      default:     return depth + 2;
    endcase
  endfunction

endpackage

// File: rtl/serrx_clkgen.sv
module serrx_clkgen
  import serrx_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  input  logic              sdata,
  output logic              sclk,
  output logic              done,
  output logic [DATA_W-1:0] shreg,
  output logic              busy
);

  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_PERIOD - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  sclk_state_t      st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitc;

  assign busy = (st != SM_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SM_IDLE;
      sclk  <= 1'b1;
      cnt   <= '0;
      bitc  <= '0;
      done  <= 1'b0;
      shreg <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SM_IDLE: begin
          if (start_ok) begin
            st   <= SM_LOW;
            sclk <= 1'b0;
            cnt  <= CNT_LOAD;
            bitc <= '0;
          end
        end
        SM_LOW: begin
          if (cnt == '0) begin
            st    <= SM_HIGH;
            sclk  <= 1'b1;
            cnt   <= CNT_LOAD;
            shreg <= {sdata, shreg[DATA_W-1:1]};
            if (bitc == LAST_BIT) done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SM_HIGH: begin
          if (cnt == '0) begin
            if (bitc == LAST_BIT) begin
              st <= SM_IDLE;
            end else begin
              st   <= SM_LOW;
              sclk <= 1'b0;
              cnt  <= CNT_LOAD;
              bitc <= bitc + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st   <= SM_IDLE;
          sclk <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNTW-1:0]   count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

endmodule

// File: rtl/serrx_store.sv
module serrx_store
  import serrx_pkg::*;
#(
  parameter int MODE       = MODE_FIFO,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              avail,
  output logic              room,
  output logic              full_all
);

  localparam bit USE_SHF  = (MODE != MODE_SINGLE);
  localparam bit USE_FIFO = (MODE == MODE_FIFO);

  logic              shf_full, buf_full;
  logic [DATA_W-1:0] shf_data, buf_data;
  logic              fifo_empty, fifo_full;
  logic [DATA_W-1:0] fifo_head;
  logic              pop_ok, move_sb, move_bf, buf_pop;

  always_comb begin
    avail   = USE_FIFO ? !fifo_empty : buf_full;
    pop_ok  = rd_stb && avail;
    move_sb = USE_SHF && shf_full && !buf_full;
    move_bf = USE_FIFO && buf_full && !fifo_full;
    buf_pop = USE_FIFO ? move_bf : pop_ok;
    rd_data = USE_FIFO ? fifo_head : buf_data;
    room    = USE_SHF ? !shf_full : !buf_full;
    case (MODE)
      MODE_SINGLE: full_all = buf_full;
      MODE_DOUBLE: full_all = shf_full && buf_full;
      default:     full_all = shf_full && buf_full && fifo_full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shf_full <= 1'b0;
      shf_data <= '0;
    end else if (USE_SHF && cap_valid) begin
      shf_full <= 1'b1;
      shf_data <= cap_data;
    end else if (move_sb) begin
      shf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (!USE_SHF && cap_valid) begin
      buf_full <= 1'b1;
      buf_data <= cap_data;
    end else if (move_sb) begin
      buf_full <= 1'b1;
      buf_data <= shf_data;
    end else if (buf_pop) begin
      buf_full <= 1'b0;
    end
  end

  generate
    if (USE_FIFO) begin : g_fifo
      serrx_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (FIFO_DEPTH)
      ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (move_bf),
        .din  (buf_data),
        .pop  (pop_ok),
        .head (fifo_head),
        .empty(fifo_empty),
        .full (fifo_full)
      );
    end else begin : g_nofifo
      assign fifo_head  = '0;
      assign fifo_empty = 1'b1;
      assign fifo_full  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sclk_rx_flowstop.sv
module sclk_rx_flowstop
  import serrx_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int DATA_W      = 8,
  parameter int MODE        = MODE_FIFO,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              auto_dis,
  input  logic              rd_stb,
  output logic              sclk,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              rx_enable,
  output logic              store_full
);

  logic              gen_busy, gen_done;
  logic [DATA_W-1:0] gen_byte;
  logic              room, full_all;
  logic              rx_en_q;
  logic              hw_clear;

  assign hw_clear = auto_dis && rx_en_q && full_all && !gen_busy;

  always_ff @(posedge clk) begin
    if (rst)           rx_en_q <= 1'b0;
    else if (en_wr)    rx_en_q <= en_val;
    else if (hw_clear) rx_en_q <= 1'b0;
  end

  serrx_clkgen #(
    .HALF_PERIOD(HALF_PERIOD),
    .DATA_W     (DATA_W)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .start_ok(rx_en_q && room),
    .sdata   (sdata),
    .sclk    (sclk),
    .done    (gen_done),
    .shreg   (gen_byte),
    .busy    (gen_busy)
  );

  serrx_store #(
    .MODE      (MODE),
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .cap_valid(gen_done),
    .cap_data (gen_byte),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .avail    (data_avail),
    .room     (room),
    .full_all (full_all)
  );

  assign rx_enable  = rx_en_q;
  assign store_full = full_all;

endmodule

// File: rtl/serrx_chk.sv
module serrx_chk #(
  parameter int HALF_PERIOD = 4,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              rx_enable,
  input logic              data_avail,
  input logic              rd_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              store_full,
  input logic              auto_dis,
  input logic              en_wr,
  input logic              gen_busy,
  input logic              room
);

  int low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= 0;
    else if (!sclk) low_cnt <= low_cnt + 1;
    else            low_cnt <= 0;
  end

  AST_LOW_PHASE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> ($past(low_cnt) == HALF_PERIOD - 1)); // R2

  AST_START_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk) && !$past(gen_busy)) |-> ($past(room) && $past(rx_enable))); // R7

  AST_PARKED_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    store_full |-> sclk); // R7

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (auto_dis && rx_enable && store_full && !gen_busy && !en_wr) |=> !rx_enable); // R8

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (data_avail && !rd_stb) |=> (data_avail && $stable(rd_data))); // R6

endmodule

bind sclk_rx_flowstop serrx_chk #(
  .HALF_PERIOD(HALF_PERIOD),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sclk      (sclk),
  .rx_enable (rx_enable),
  .data_avail(data_avail),
  .rd_stb    (rd_stb),
  .rd_data   (rd_data),
  .store_full(store_full),
  .auto_dis  (auto_dis),
  .en_wr     (en_wr),
  .gen_busy  (gen_busy),
  .room      (room)
);

// File: tb/serrx_slave_model.sv
module serrx_slave_model #(
  parameter int SEED = 1
) (
  input  logic sclk,
  output logic sdata,
  output int   sent,
  output int   bit_pos
);

  logic [7:0] bytes [64];

  initial begin
    void'($urandom(SEED));
    for (int i = 0; i < 64; i++) bytes[i] = 8'($urandom);
    sdata   = 1'b0;
    sent    = 0;
    bit_pos = 0;
  end

  always @(negedge sclk) begin
    sdata = bytes[sent % 64][bit_pos];
    if (bit_pos == 7) begin
      bit_pos = 0;
      sent    = sent + 1;
    end else begin
      bit_pos = bit_pos + 1;
    end
  end

endmodule

// File: tb/sclk_rx_flowstop_test.sv
module sclk_rx_flowstop_test;

  localparam int HP    = 2;
  localparam int DEPTH = 4;
  localparam int W     = 8;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic         sd  [3];
  logic         ew  [3];
  logic         ev  [3];
  logic         ad  [3];
  logic         rs  [3];
  logic         sc  [3];
  logic [W-1:0] rdd [3];
  logic         av  [3];
  logic         ren [3];
  logic         sf  [3];
  int           sent[3];
  int           bph [3];
  int           rcvd[3];
  int           nchk = 0;
  int           nfail = 0;

  sclk_rx_flowstop #(.HALF_PERIOD(HP), .DATA_W(W), .MODE(0), .FIFO_DEPTH(DEPTH)) uut_single (
    .clk(clk), .rst(rst), .sdata(sd[0]), .en_wr(ew[0]), .en_val(ev[0]), .auto_dis(ad[0]),
    .rd_stb(rs[0]), .sclk(sc[0]), .rd_data(rdd[0]), .data_avail(av[0]), .rx_enable(ren[0]),
    .store_full(sf[0]));

  sclk_rx_flowstop #(.HALF_PERIOD(HP), .DATA_W(W), .MODE(1), .FIFO_DEPTH(DEPTH)) uut_double (
    .clk(clk), .rst(rst), .sdata(sd[1]), .en_wr(ew[1]), .en_val(ev[1]), .auto_dis(ad[1]),
    .rd_stb(rs[1]), .sclk(sc[1]), .rd_data(rdd[1]), .data_avail(av[1]), .rx_enable(ren[1]),
    .store_full(sf[1]));

  sclk_rx_flowstop #(.HALF_PERIOD(HP), .DATA_W(W), .MODE(2), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .sdata(sd[2]), .en_wr(ew[2]), .en_val(ev[2]), .auto_dis(ad[2]),
    .rd_stb(rs[2]), .sclk(sc[2]), .rd_data(rdd[2]), .data_avail(av[2]), .rx_enable(ren[2]),
    .store_full(sf[2]));

  serrx_slave_model #(.SEED(11)) slv0 (.sclk(sc[0]), .sdata(sd[0]), .sent(sent[0]), .bit_pos(bph[0]));
  serrx_slave_model #(.SEED(22)) slv1 (.sclk(sc[1]), .sdata(sd[1]), .sent(sent[1]), .bit_pos(bph[1]));
  serrx_slave_model #(.SEED(33)) slv2 (.sclk(sc[2]), .sdata(sd[2]), .sent(sent[2]), .bit_pos(bph[2]));

  function automatic logic [W-1:0] exp_byte(input int m, input int n);
    case (m)
      0:       return slv0.bytes[n % 64];
      1:       return slv1.bytes[n % 64];
      default: return slv2.bytes[n % 64];
    endcase
  endfunction

  function automatic int capacity(input int m);
    case (m)
      0:       return 1;
      1:       return 2;
      default: return DEPTH + 2;
    endcase
  endfunction

  int low_run = 0;
  int width_bad = 0;
  int lows = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!sc[2]) low_run = low_run + 1;
      else if (low_run != 0) begin
        lows = lows + 1;
        if (low_run != HP) width_bad = width_bad + 1;
        low_run = 0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_enable(input int m, input logic val);
    ew[m] = 1'b1;
    ev[m] = val;
    tick(1);
    ew[m] = 1'b0;
  endtask

  task automatic read_one(input int m, input string req);
    int waited = 0;
    while (!av[m] && waited < 400) begin
      tick(1);
      waited++;
    end
    if (!av[m]) begin
      check(1'b0, req, "data never became available", 0, 1);
    end else begin
      check(rdd[m] == exp_byte(m, rcvd[m]), req, "byte order/value",
            int'(rdd[m]), int'(exp_byte(m, rcvd[m])));
      rcvd[m]++;
      rs[m] = 1'b1;
      tick(1);
      rs[m] = 1'b0;
    end
  endtask

  task automatic drain(input int m, input string req);
    int idle = 0;
    while (idle < 20) begin
      if (av[m]) begin
        read_one(m, req);
        idle = 0;
      end else begin
        tick(1);
        idle++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(20240));
    for (int m = 0; m < 3; m++) begin
      ew[m] = 1'b0; ev[m] = 1'b0; ad[m] = 1'b0; rs[m] = 1'b0; rcvd[m] = 0;
    end
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(1);

    // R1: reset state
    for (int m = 0; m < 3; m++) begin
      check(sc[m] == 1'b1,  "R1", "sclk after reset", int'(sc[m]), 1);
      check(av[m] == 1'b0,  "R1", "data_avail after reset", int'(av[m]), 0);
      check(ren[m] == 1'b0, "R1", "rx_enable after reset", int'(ren[m]), 0);
      check(sf[m] == 1'b0,  "R1", "store_full after reset", int'(sf[m]), 0);
    end

    // R9: read strobe on empty storage
    for (int m = 0; m < 3; m++) rs[m] = 1'b1;
    tick(1);
    for (int m = 0; m < 3; m++) rs[m] = 1'b0;
    tick(3);
    for (int m = 0; m < 3; m++)
      check(av[m] == 1'b0, "R9", "avail after empty read", int'(av[m]), 0);

    // R3 R4 R5 R7: fill until the clock parks
    for (int m = 0; m < 3; m++) set_enable(m, 1'b1);
    tick(800);
    for (int m = 0; m < 3; m++) begin
      check(sent[m] == capacity(m), (m == 0) ? "R3" : (m == 1) ? "R4" : "R5",
            "bytes clocked before stop", sent[m], capacity(m));
      check(sf[m] == 1'b1, "R7", "store_full when parked", int'(sf[m]), 1);
      check(sc[m] == 1'b1, "R7", "sclk parked high", int'(sc[m]), 1);
      check(bph[m] == 0,   "R7", "stopped on byte boundary", bph[m], 0);
    end
    tick(200);
    for (int m = 0; m < 3; m++)
      check(sent[m] == capacity(m), "R7", "no byte while full", sent[m], capacity(m));

    // R3 R4 R5: one read releases exactly one byte (R9: first byte not skipped)
    for (int m = 0; m < 3; m++) read_one(m, "R9");
    tick(200);
    for (int m = 0; m < 3; m++) begin
      check(sent[m] == capacity(m) + 1, (m == 0) ? "R3" : (m == 1) ? "R4" : "R5",
            "bytes after one read", sent[m], capacity(m) + 1);
      check(sf[m] == 1'b1, "R7", "full again after refill", int'(sf[m]), 1);
    end

    // R6: random read gaps, ordered delivery
    for (int m = 0; m < 3; m++)
      for (int i = 0; i < 25; i++) begin
        tick($urandom_range(0, 60));
        read_one(m, "R6");
      end

    // R6: stop and drain, nothing lost
    for (int m = 0; m < 3; m++) set_enable(m, 1'b0);
    tick(100);
    for (int m = 0; m < 3; m++) begin
      drain(m, "R6");
      check(sent[m] == rcvd[m], "R6", "bytes sent vs read", rcvd[m], sent[m]);
      check(sf[m] == 1'b0, "R6", "store_full after drain", int'(sf[m]), 0);
    end

    // R10: disable in mid-byte on the FIFO variant
    set_enable(2, 1'b1);
    @(negedge sc[2]);
    tick(3);
    set_enable(2, 1'b0);
    tick(200);
    check(sent[2] == rcvd[2] + 1, "R10", "byte finished after disable", sent[2], rcvd[2] + 1);
    check(bph[2] == 0,    "R10", "source at byte boundary", bph[2], 0);
    check(av[2] == 1'b1,  "R10", "finished byte readable", int'(av[2]), 1);
    check(sc[2] == 1'b1,  "R10", "sclk parked high", int'(sc[2]), 1);
    drain(2, "R10");
    tick(200);
    check(sent[2] == rcvd[2], "R10", "no new byte after disable", sent[2], rcvd[2]);

    // R8: auto-disable on the double-buffer variant
    ad[1] = 1'b1;
    set_enable(1, 1'b1);
    tick(400);
    check(ren[1] == 1'b0, "R8", "rx_enable cleared on fill", int'(ren[1]), 0);
    check(sent[1] - rcvd[1] == 2, "R8", "bytes held at auto stop", sent[1] - rcvd[1], 2);
    check(sf[1] == 1'b1, "R8", "store_full at auto stop", int'(sf[1]), 1);
    read_one(1, "R8");
    read_one(1, "R8");
    tick(300);
    check(sent[1] == rcvd[1], "R8", "no restart after reads", sent[1], rcvd[1]);
    check(ren[1] == 1'b0, "R8", "rx_enable stays clear", int'(ren[1]), 0);
    check(sc[1] == 1'b1,  "R8", "sclk idle high", int'(sc[1]), 1);

    // R2: low phase width measured at the port; LSB-first covered by byte checks
    check(lows > 0, "R2", "low phases observed", lows, 1);
    check(width_bad == 0, "R2", "low phases of wrong width", width_bad, 0);

    summary();
    $finish;
  end

endmodule